// File: doc/BRIEF.md
# Eight-Line Programmable Interrupt Controller

This block gathers eight interrupt request lines and raises one interrupt output toward a processor. Software reaches it through a byte-wide register port that has two addresses. Address 0 is the command port and address 1 is the data port. Before any interrupt is forwarded, a short programming sequence must be written. That sequence sets the vector base, chooses edge or level sensing, and optionally enables automatic end-of-interrupt.

Once programmed, the block latches requests and applies a mask. It then resolves a fixed priority, where line 0 is highest, against the lines already in service. When the processor pulses the acknowledge strobe, the block drives the vector for the winning line in that same cycle and moves the line into service. Service ends with a specific end-of-interrupt command, or at acknowledge when automatic end-of-interrupt is on. If the request has disappeared by the time of acknowledge, the block answers with the lowest-priority vector and leaves the in-service state alone.

Top module: `irq_ctrl_core`

## Requirements
- R1: After reset the mask register reads 0xFF, the in-service register reads 0x00 and irq_out is low. irq_out stays low, whatever the requests and mask, until a programming sequence completes.
- R2: A command write with bit 4 set starts programming. Bit 3 of that word selects level sensing (1) or edge sensing (0), and bit 0 says whether a mode word follows. The next data writes are taken, in order, as the vector base, a cascade word that is ignored, and, only if bit 0 was set, the mode word. When bit 0 is clear, automatic end-of-interrupt is off and the data write after the cascade word loads the mask.
- R3: An acknowledge that grants line n drives vec_out = base + n (modulo 256) while inta is high.
- R4: Among unmasked pending lines, the lowest index wins.
- R5: A pending line is presented on irq_out only if no in-service bit at its own or a lower index is set.
- R6: The clock edge that ends a granting acknowledge sets the winner's in-service bit and clears its request bit.
- R7: A command write of 0x60+n clears in-service bit n and no other bit.
- R8: A command write of 0x0A makes command-port reads return the request register, and 0x0B makes them return the in-service register. The choice persists until it is changed. Data-port reads return the mask.
- R9: A data write outside programming loads the mask. A 1 bit stops that line from reaching irq_out.
- R10: With mode word bit 1 set, an acknowledge leaves the in-service register unchanged.
- R11: An acknowledge while irq_out is low returns base + 7 and changes no in-service bit, even when line 7 is masked.
- R12: In edge mode a request bit sets only on a rising input and clears at acknowledge or when the input falls. In level mode the request bit follows the input.
- R13: The start of programming clears the in-service register and sets the read selection back to the request register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_rd | input | 1 | Register read enable, qualifies bus_rdata |
| bus_addr | input | 1 | 0 selects the command port, 1 selects the data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, zero when bus_rd is low |
| irq_in | input | 8 | Interrupt request lines |
| inta | input | 1 | Acknowledge strobe, one cycle per acknowledge |
| irq_out | output | 1 | Interrupt request toward the processor |
| vec_out | output | 8 | Vector, valid while inta is high, zero otherwise |

## Verification
A corrupted in-service bit shows up within one cycle, either as irq_out held low while an unmasked request waits, or as a lower-priority line breaking through. It also appears on the next in-service read. A wrong request bit shows at the next acknowledge, as the wrong vector or as a spurious base + 7. A wrong programming state shows up as data writes landing in the mask instead of the base. The bench therefore follows each step of the sequence with an acknowledge or a register read in the very next cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_BASE = 2'd1,
    ST_CASC = 2'd2,
    ST_MODE = 2'd3
  } prog_st_e;

  // command word fields
  localparam int unsigned CMD_PROG_BIT   = 4;
  localparam int unsigned CMD_LEVEL_BIT  = 3;
  localparam int unsigned CMD_HASMODE_BIT = 0;
  localparam int unsigned MODE_AUTO_BIT  = 1;
  localparam logic [2:0]  OP_EOI_CODE    = 3'b011;
  localparam logic [2:0]  OP_SEL_CODE    = 3'b000;
endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/irqc_regport.sv
module irqc_regport
  import irqc_pkg::*;
#(
  parameter int unsigned DW     = 8,
  parameter int unsigned NLINES = 8,
  localparam int unsigned IDXW  = $clog2(NLINES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic            bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [NLINES-1:0] imr_q,
  output logic [DW-1:0]   base_q,
  output logic            level_q,
  output logic            aeoi_q,
  output logic            done_q,
  output logic            rsel_isr_q,
  output logic            prog_start,
  output logic            eoi_valid,
  output logic [IDXW-1:0] eoi_idx
);
  prog_st_e        st_q, st_n;
  logic [NLINES-1:0] imr_n;
  logic [DW-1:0]   base_n;
  logic            level_n, aeoi_n, done_n, rsel_n;
  logic            hasmode_q, hasmode_n;

  always_comb begin
    st_n       = st_q;
    imr_n      = imr_q;
    base_n     = base_q;
    level_n    = level_q;
    aeoi_n     = aeoi_q;
    done_n     = done_q;
    rsel_n     = rsel_isr_q;
    hasmode_n  = hasmode_q;
    prog_start = 1'b0;
    eoi_valid  = 1'b0;
    eoi_idx    = bus_wdata[IDXW-1:0];
    if (bus_wr && !bus_addr) begin
      if (bus_wdata[CMD_PROG_BIT]) begin
        prog_start = 1'b1;
        st_n       = ST_BASE;
        level_n    = bus_wdata[CMD_LEVEL_BIT];
        hasmode_n  = bus_wdata[CMD_HASMODE_BIT];
        aeoi_n     = 1'b0;
        done_n     = 1'b0;
        rsel_n     = 1'b0;
      end else if (bus_wdata[7:5] == OP_EOI_CODE && !bus_wdata[3]) begin
        eoi_valid = 1'b1;
      end else if (bus_wdata[7:5] == OP_SEL_CODE && bus_wdata[3] && bus_wdata[1]) begin
        rsel_n = bus_wdata[0];
      end
    end else if (bus_wr && bus_addr) begin
      unique case (st_q)
        ST_RUN:  imr_n = bus_wdata[NLINES-1:0];
        ST_BASE: begin
          base_n = bus_wdata;
          st_n   = ST_CASC;
        end
        ST_CASC: begin
          if (hasmode_q) begin
            st_n = ST_MODE;
          end else begin
            st_n   = ST_RUN;
            done_n = 1'b1;
          end
        end
        ST_MODE: begin
          aeoi_n = bus_wdata[MODE_AUTO_BIT];
          st_n   = ST_RUN;
          done_n = 1'b1;
        end
        default: st_n = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_RUN;
      imr_q      <= '1;
      base_q     <= '0;
      level_q    <= 1'b0;
      aeoi_q     <= 1'b0;
      done_q     <= 1'b0;
      rsel_isr_q <= 1'b0;
      hasmode_q  <= 1'b0;
    end else if (bus_wr) begin
      st_q       <= st_n;
      imr_q      <= imr_n;
      base_q     <= base_n;
      level_q    <= level_n;
      aeoi_q     <= aeoi_n;
      done_q     <= done_n;
      rsel_isr_q <= rsel_n;
      hasmode_q  <= hasmode_n;
    end
  end
endmodule

// File: rtl/irqc_req_latch.sv
module irqc_req_latch #(
  parameter int unsigned NLINES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              level,
  input  logic [NLINES-1:0] irq_in,
  input  logic [NLINES-1:0] ack_clr,
  output logic [NLINES-1:0] irr_q
);
  for (genvar i = 0; i < NLINES; i++) begin : g_line
    logic req_q, req_n, prev_q;

    always_comb begin
      if (level) begin
        req_n = irq_in[i];
      end else begin
        req_n = ((req_q & irq_in[i]) | (irq_in[i] & ~prev_q)) & ~ack_clr[i];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        req_q  <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        req_q  <= req_n;
        prev_q <= irq_in[i];
      end
    end

    assign irr_q[i] = req_q;
  end
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int unsigned NLINES = 8,
  localparam int unsigned IDXW  = $clog2(NLINES)
) (
  input  logic [NLINES-1:0] irr,
  input  logic [NLINES-1:0] imr,
  input  logic [NLINES-1:0] isr,
  output logic              req,
  output logic [IDXW-1:0]   win_idx,
  output logic [NLINES-1:0] win_oh
);
  logic [NLINES-1:0] blocked;
  logic [NLINES-1:0] eligible;

  assign blocked[0] = isr[0];
  for (genvar i = 1; i < NLINES; i++) begin : g_blk
    assign blocked[i] = blocked[i-1] | isr[i];
  end

  assign eligible = irr & ~imr & ~blocked;

  always_comb begin
    req     = 1'b0;
    win_idx = '0;
    win_oh  = '0;
    for (int i = 0; i < NLINES; i++) begin
      if (eligible[i] && !req) begin
        req       = 1'b1;
        win_idx   = IDXW'(i);
        win_oh[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_ctrl_core.sv
module irq_ctrl_core #(
  parameter int unsigned DW     = 8,
  parameter int unsigned NLINES = 8,
  localparam int unsigned IDXW  = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NLINES-1:0] irq_in,
  input  logic              inta,
  output logic              irq_out,
  output logic [DW-1:0]     vec_out
);
  localparam logic [IDXW-1:0] SPUR_IDX = IDXW'(NLINES - 1);

  logic              rst_s_n;
  logic [NLINES-1:0] imr_q, irr_q, isr_q, isr_n;
  logic [DW-1:0]     base_q;
  logic              level_q, aeoi_q, init_done_q, rsel_isr_q;
  logic              prog_start, eoi_valid;
  logic [IDXW-1:0]   eoi_idx, win_idx, vec_idx;
  logic [NLINES-1:0] win_oh, ack_clr;
  logic              req, grant, isr_en;

  irqc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  irqc_regport #(.DW(DW), .NLINES(NLINES)) u_regs (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .imr_q      (imr_q),
    .base_q     (base_q),
    .level_q    (level_q),
    .aeoi_q     (aeoi_q),
    .done_q     (init_done_q),
    .rsel_isr_q (rsel_isr_q),
    .prog_start (prog_start),
    .eoi_valid  (eoi_valid),
    .eoi_idx    (eoi_idx)
  );

  irqc_req_latch #(.NLINES(NLINES)) u_irr (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .level   (level_q),
    .irq_in  (irq_in),
    .ack_clr (ack_clr),
    .irr_q   (irr_q)
  );

  irqc_prio #(.NLINES(NLINES)) u_prio (
    .irr     (irr_q),
    .imr     (imr_q),
    .isr     (isr_q),
    .req     (req),
    .win_idx (win_idx),
    .win_oh  (win_oh)
  );

  assign irq_out = init_done_q & req;
  assign grant   = inta & irq_out;
  assign ack_clr = grant ? win_oh : '0;
  assign isr_en  = prog_start | eoi_valid | grant;

  always_comb begin
    isr_n = isr_q;
    if (prog_start) begin
      isr_n = '0;
    end else begin
      if (eoi_valid) isr_n[eoi_idx] = 1'b0;
      if (grant && !aeoi_q) isr_n = isr_n | win_oh;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      isr_q <= '0;
    end else if (isr_en) begin
      isr_q <= isr_n;
    end
  end

  assign vec_idx = grant ? win_idx : SPUR_IDX;
  assign vec_out = inta ? (base_q + DW'(vec_idx)) : '0;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (bus_addr)        bus_rdata = DW'(imr_q);
      else if (rsel_isr_q) bus_rdata = DW'(isr_q);
      else                 bus_rdata = DW'(irr_q);
    end
  end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int unsigned DW     = 8,
  parameter int unsigned NLINES = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              inta,
  input logic              bus_wr,
  input logic              irq_out,
  input logic [DW-1:0]     vec_out,
  input logic [DW-1:0]     base_q,
  input logic [NLINES-1:0] irr_q,
  input logic [NLINES-1:0] imr_q,
  input logic [NLINES-1:0] isr_q,
  input logic              init_done_q,
  input logic              aeoi_q
);
  assert_quiet_until_init_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done_q |-> !irq_out);

  assert_mask_gates_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (|(irr_q & ~imr_q)));

  assert_grant_enters_service_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && irq_out && !aeoi_q && !bus_wr) |=> $countones(isr_q) == $past($countones(isr_q)) + 1);

  assert_auto_eoi_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && aeoi_q && !bus_wr) |=> isr_q == $past(isr_q));

  assert_spurious_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !irq_out && !bus_wr) |=> isr_q == $past(isr_q));

  assert_spurious_vector_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !irq_out) |-> vec_out == base_q + DW'(NLINES - 1));

  assert_vector_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    inta |-> DW'(vec_out - base_q) < DW'(NLINES));
endmodule

bind irq_ctrl_core irqc_chk #(.DW(DW), .NLINES(NLINES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .inta        (inta),
  .bus_wr      (bus_wr),
  .irq_out     (irq_out),
  .vec_out     (vec_out),
  .base_q      (base_q),
  .irr_q       (irr_q),
  .imr_q       (imr_q),
  .isr_q       (isr_q),
  .init_done_q (init_done_q),
  .aeoi_q      (aeoi_q)
);

// File: tb/sim_irq_ctrl_core.sv
module sim_irq_ctrl_core;
  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n, bus_wr, bus_rd, bus_addr, inta;
  logic [7:0] bus_wdata, irq_in;
  wire  [7:0] bus_rdata, vec_out;
  wire        irq_out;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];

  int checks = 0;
  int errors = 0;

  irq_ctrl_core u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_in    (irq_in),
    .inta      (inta),
    .irq_out   (irq_out),
    .vec_out   (vec_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor: compares vectors and read data against queued expectations
  always @(negedge clk) begin
    if (rst_n && (inta || bus_rd)) begin
      logic [7:0] act;
      act = inta ? vec_out : bus_rdata;
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected output: actual=%02h expected=none", act);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual=%02h expected=%02h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    cyc(1);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, input logic [7:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    bus_rd = 1'b1; bus_addr = a;
    cyc(1);
    bus_rd = 1'b0;
  endtask

  task automatic ack(input logic [7:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    inta = 1'b1;
    cyc(1);
    inta = 1'b0;
  endtask

  task automatic set_irq(input logic [7:0] v);
    irq_in = v;
    cyc(1);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    checks++;
    if (irq_out !== e) begin
      errors++;
      $display("FAIL %s: actual irq_out=%0b expected=%0b", tag, irq_out, e);
    end
  endtask

  task automatic finish_run();
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual pending=%0d expected=0", sb_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = 1'b0;
    bus_wdata = '0; irq_in = '0; inta = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);

    // R1 reset state and silence before programming
    chk_irq(1'b0, "R1 reset irq_out");
    rd(1'b1, 8'hFF, "R1 reset mask");
    wr(1'b0, 8'h0B);
    rd(1'b0, 8'h00, "R1 reset in-service");
    wr(1'b0, 8'h0A);
    wr(1'b1, 8'h00);
    set_irq(8'h01);
    chk_irq(1'b0, "R1 unprogrammed stays low");
    ack(8'h07, "R11 spurious before programming");
    set_irq(8'h00);

    // R2 program: edge mode, base 0x20, mode word without auto-EOI
    wr(1'b0, 8'h11);
    wr(1'b1, 8'h20);
    wr(1'b1, 8'h04);
    wr(1'b1, 8'h01);
    rd(1'b1, 8'h00, "R2 mask untouched by programming words");
    chk_irq(1'b0, "R1 no request after programming");

    // R3 R6 single request
    set_irq(8'h08);
    chk_irq(1'b1, "R6 request presented");
    ack(8'h23, "R3 vector base+3");
    wr(1'b0, 8'h0B);
    rd(1'b0, 8'h08, "R6 in-service bit 3 set");
    wr(1'b0, 8'h0A);
    rd(1'b0, 8'h00, "R12 edge request cleared at ack with input high");

    // R5 blocking and nesting
    set_irq(8'h28);
    chk_irq(1'b0, "R5 lower line blocked by service");
    set_irq(8'h2A);
    chk_irq(1'b1, "R5 higher line breaks through");
    ack(8'h21, "R4 nested vector base+1");
    wr(1'b0, 8'h0B);
    rd(1'b0, 8'h0A, "R6 nested in-service");
    wr(1'b0, 8'h61);
    rd(1'b0, 8'h08, "R7 specific EOI clears only bit 1");
    chk_irq(1'b0, "R5 still blocked by bit 3");
    wr(1'b0, 8'h63);
    rd(1'b0, 8'h00, "R7 EOI bit 3");
    chk_irq(1'b1, "R5 released after EOI");
    ack(8'h25, "R3 vector base+5");
    wr(1'b0, 8'h65);

    // R4 simultaneous requests
    set_irq(8'h00);
    set_irq(8'h44);
    ack(8'h22, "R4 line 2 beats line 6");
    wr(1'b0, 8'h62);
    ack(8'h26, "R4 then line 6");
    wr(1'b0, 8'h66);
    rd(1'b0, 8'h00, "R7 all service ended");

    // R9 masking
    set_irq(8'h00);
    wr(1'b1, 8'h04);
    rd(1'b1, 8'h04, "R8 data read returns mask");
    set_irq(8'h14);
    chk_irq(1'b1, "R9 unmasked line 4 pending");
    ack(8'h24, "R9 masked line 2 skipped");
    wr(1'b0, 8'h64);
    chk_irq(1'b0, "R9 masked pending line silent");
    wr(1'b0, 8'h0A);
    rd(1'b0, 8'h04, "R8 request register read");

    // R11 R12 vanished request, line 7 masked
    set_irq(8'h00);
    wr(1'b1, 8'h80);
    set_irq(8'h01);
    chk_irq(1'b1, "R12 rising edge latched");
    set_irq(8'h00);
    chk_irq(1'b0, "R12 edge request drops with input");
    ack(8'h27, "R11 spurious vector with line 7 masked");
    wr(1'b0, 8'h0B);
    rd(1'b0, 8'h00, "R11 in-service unchanged");

    // R13 reprogramming: level mode, base 0x40, auto-EOI
    set_irq(8'h01);
    ack(8'h20, "R3 vector base+0");
    rd(1'b0, 8'h01, "R6 in-service bit 0");
    wr(1'b0, 8'h19);
    chk_irq(1'b0, "R1 silent during programming");
    wr(1'b1, 8'h40);
    wr(1'b1, 8'h04);
    wr(1'b1, 8'h03);
    rd(1'b0, 8'h01, "R13 read selection back to requests");
    wr(1'b0, 8'h0B);
    rd(1'b0, 8'h00, "R13 in-service cleared");
    rd(1'b1, 8'h80, "R13 mask kept");
    chk_irq(1'b1, "R12 level request present");
    ack(8'h40, "R3 new base");
    rd(1'b0, 8'h00, "R10 auto-EOI leaves service empty");
    chk_irq(1'b1, "R12 level request persists");
    set_irq(8'h00);
    chk_irq(1'b0, "R12 level request follows input");

    // R2 short sequence without mode word
    wr(1'b0, 8'h10);
    wr(1'b1, 8'h60);
    wr(1'b1, 8'h04);
    wr(1'b1, 8'hFE);
    rd(1'b1, 8'hFE, "R2 fourth write loads mask");
    set_irq(8'h03);
    ack(8'h60, "R2 base from short sequence");
    wr(1'b0, 8'h0B);
    rd(1'b0, 8'h01, "R2 auto-EOI off without mode word");

    cyc(2);
    finish_run();
  end
endmodule